// File: doc/BRIEF.md
# Chip-Select Interleave Bit Swapper

This block remaps a normalized DRAM input address before it reaches the chip-select decoder, so that consecutive sweeps over every row and internal bank of one chip-select continue on the next chip-select. It does this by exchanging a small group of the lowest row bits with the same number of the lowest chip-selection bits. Both swap positions follow the device geometry at run time. The low group starts just above the highest internal bank-address bit. The high group starts at the leading one of the chip-select size, which is the first address bit above the in-chip offset.

The caller supplies the address, the chip-select size as a byte count, the index of the top bank-address bit, the requested interleave factor, a bus-width mode and a flag that marks the largest chip-select modes. The block returns the remapped address, the two computed swap positions, the accepted factor, and a flag that says whether the interleave is active. The arithmetic is combinational. An optional output register stage (parameter `REG_OUT`, on by default) adds one cycle of latency and carries a valid bit.

Top module: `csi_swapper`

## Requirements
- R1: A factor of 2, 4 or 8 selects a swap group of 1, 2 or 3 bits. When the interleave is active, `factor_out` repeats the requested factor and `intlv_on` is 1.
- R2: Any factor other than 2, 4 or 8 disables the interleave. `factor_out` is then 0 and `intlv_on` is 0.
- R3: `lo_bit` always equals `last_bank` + 1, which is the first row bit.
- R4: `hi_bit` is the zero-based position of the most significant set bit of `cs_size`. A `cs_size` of zero reports `hi_bit` = 0 and disables the interleave.
- R5: When active with n swap bits, `addr_out[lo_bit+k]` = `addr_in[hi_bit+k]` and `addr_out[hi_bit+k]` = `addr_in[lo_bit+k]` for k = 0..n-1. Every other bit passes unchanged.
- R6: When the interleave is disabled, `addr_out` equals `addr_in` bit for bit.
- R7: A factor of 8 is refused, with factor 0 and a pass-through address, when `wide_mode` = 1 (128-bit bus) and `cs_large` = 1. The same request with `wide_mode` = 0 is accepted.
- R8: The interleave is disabled when the low group would reach the high group (`lo_bit` + n > `hi_bit`) or when the high group would pass the top address bit (`hi_bit` + n > `ADDR_W`).
- R9: With `REG_OUT` = 1, every output takes its new value one clock after the inputs, and `out_valid` follows `in_valid` with the same delay. An active-low reset clears `out_valid`, `addr_out`, `factor_out` and `intlv_on` to zero.
- R10: Feeding the remapped address back in with the same geometry and factor returns the original address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input qualifier |
| addr_in | input | ADDR_W | Normalized input address |
| cs_size | input | SIZE_W | Chip-select size in bytes |
| last_bank | input | POS_W | Bit index of the highest bank-address bit |
| factor | input | FACT_W | Requested interleave factor |
| wide_mode | input | 1 | 1 = 128-bit bus, 0 = 64-bit bus |
| cs_large | input | 1 | Marks the largest chip-select modes |
| out_valid | output | 1 | Output qualifier |
| addr_out | output | ADDR_W | Remapped address |
| lo_bit | output | LOC_W | First bit of the low (row) group |
| hi_bit | output | LOC_W | First bit of the high (chip-select) group |
| factor_out | output | FACT_W | Accepted factor, 0 when disabled |
| intlv_on | output | 1 | Interleave active |

## Verification
The hardest cases to reach are the geometry edges. These are a low group that ends exactly at the high group, a high group whose last bit is the top address bit, and the same sizes shifted by one so that they just fail. Random sizes and bank positions rarely hit these boundaries. The stimulus therefore places them directly with chosen power-of-two sizes and bank indices. It also runs the 8-way refusal under both bus widths. The random part mixes legal and illegal factors with sizes that are zero, powers of two and arbitrary values. Each result is fed back in to confirm that the swap undoes itself.

// File: rtl/csi_pkg.sv
package csi_pkg;

  localparam int MAX_W = 64;

  // Number of swap bits for a requested factor; 0 means not supported.
  function automatic int factor_nbits(input int f);
    case (f)
      2:       return 1;
      4:       return 2;
      8:       return 3;
      default: return 0;
    endcase
  endfunction

  // Exchange n bits starting at lo with n bits starting at hi.
  function automatic logic [MAX_W-1:0] swap_bits(input logic [MAX_W-1:0] a,
                                                 input int lo, input int hi,
                                                 input int n);
    logic [MAX_W-1:0] r;
    r = a;
    for (int k = 0; k < 3; k++) begin
      if (k < n && lo + k < MAX_W && hi + k < MAX_W) begin
        r[lo+k] = a[hi+k];
        r[hi+k] = a[lo+k];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/csi_lead_one.sv
module csi_lead_one #(
  parameter int W     = 64,
  parameter int POS_W = 7
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos
);
  // One-based index of the highest set bit, 0 for an all-zero input.
  always_comb begin
    pos = '0;
    for (int b = 0; b < W; b++) begin
      if (vec[b]) pos = POS_W'(b + 1);
    end
  end
endmodule

// File: rtl/csi_geom.sv
module csi_geom
  import csi_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 64,
  parameter int FACT_W = 5,
  parameter int POS_W  = 7,
  parameter int LOC_W  = 8
) (
  input  logic [SIZE_W-1:0] cs_size,
  input  logic [POS_W-1:0]  last_bank,
  input  logic [FACT_W-1:0] factor,
  input  logic              wide_mode,
  input  logic              cs_large,
  output logic [LOC_W-1:0]  lo_bit,
  output logic [LOC_W-1:0]  hi_bit,
  output logic [1:0]        nbits,
  output logic [FACT_W-1:0] factor_eff,
  output logic              enable
);
  logic [POS_W-1:0] lead_pos;
  int lo_i, hi_i, n_i;
  logic refuse, fits;

  csi_lead_one #(.W(SIZE_W), .POS_W(POS_W)) u_lead (
    .vec (cs_size),
    .pos (lead_pos)
  );

  always_comb begin
    lo_i   = int'(last_bank) + 1;
    hi_i   = (lead_pos == '0) ? 0 : int'(lead_pos) - 1;
    n_i    = factor_nbits(int'(factor));
    refuse = (factor == FACT_W'(8)) && wide_mode && cs_large;
    fits   = (lead_pos != '0) && (lo_i + n_i <= hi_i) && (hi_i + n_i <= ADDR_W);
    enable = (n_i != 0) && fits && !refuse;
    lo_bit = LOC_W'(lo_i);
    hi_bit = LOC_W'(hi_i);
    nbits  = enable ? 2'(n_i) : 2'd0;
    factor_eff = enable ? factor : '0;
  end
endmodule

// File: rtl/csi_swap_net.sv
module csi_swap_net #(
  parameter int ADDR_W = 48,
  parameter int LOC_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LOC_W-1:0]  lo_bit,
  input  logic [LOC_W-1:0]  hi_bit,
  input  logic [1:0]        nbits,
  input  logic              enable,
  output logic [ADDR_W-1:0] addr_out
);
  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    int lo_i, hi_i, n_i, src;
    always_comb begin
      lo_i = int'(lo_bit);
      hi_i = int'(hi_bit);
      n_i  = int'(nbits);
      src  = g;
      if (enable && g >= lo_i && g < lo_i + n_i)      src = hi_i + (g - lo_i);
      else if (enable && g >= hi_i && g < hi_i + n_i) src = lo_i + (g - hi_i);
      addr_out[g] = (src >= 0 && src < ADDR_W) ? addr_in[src] : 1'b0;
    end
  end
endmodule

// File: rtl/csi_swapper.sv
module csi_swapper #(
  parameter int ADDR_W  = 48,
  parameter int SIZE_W  = 64,
  parameter int FACT_W  = 5,
  parameter bit REG_OUT = 1'b1,
  localparam int POS_W  = $clog2(SIZE_W + 1),
  localparam int LOC_W  = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [SIZE_W-1:0] cs_size,
  input  logic [POS_W-1:0]  last_bank,
  input  logic [FACT_W-1:0] factor,
  input  logic              wide_mode,
  input  logic              cs_large,
  output logic              out_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic [LOC_W-1:0]  lo_bit,
  output logic [LOC_W-1:0]  hi_bit,
  output logic [FACT_W-1:0] factor_out,
  output logic              intlv_on
);
  // Combinational stage, brought out by name for the checker.
  logic [LOC_W-1:0]  lo_c, hi_c;
  logic [1:0]        nbits_c;
  logic [FACT_W-1:0] fact_c;
  logic              en_c;
  logic [ADDR_W-1:0] swp_addr_c;

  csi_geom #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .FACT_W(FACT_W),
    .POS_W(POS_W), .LOC_W(LOC_W)
  ) u_geom (
    .cs_size    (cs_size),
    .last_bank  (last_bank),
    .factor     (factor),
    .wide_mode  (wide_mode),
    .cs_large   (cs_large),
    .lo_bit     (lo_c),
    .hi_bit     (hi_c),
    .nbits      (nbits_c),
    .factor_eff (fact_c),
    .enable     (en_c)
  );

  csi_swap_net #(.ADDR_W(ADDR_W), .LOC_W(LOC_W)) u_net (
    .addr_in  (addr_in),
    .lo_bit   (lo_c),
    .hi_bit   (hi_c),
    .nbits    (nbits_c),
    .enable   (en_c),
    .addr_out (swp_addr_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid  <= 1'b0;
        addr_out   <= '0;
        lo_bit     <= '0;
        hi_bit     <= '0;
        factor_out <= '0;
        intlv_on   <= 1'b0;
      end else begin
        out_valid  <= in_valid;
        addr_out   <= swp_addr_c;
        lo_bit     <= lo_c;
        hi_bit     <= hi_c;
        factor_out <= fact_c;
        intlv_on   <= en_c;
      end
    end
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign addr_out   = swp_addr_c;
    assign lo_bit     = lo_c;
    assign hi_bit     = hi_c;
    assign factor_out = fact_c;
    assign intlv_on   = en_c;
  end
endmodule

// File: rtl/csi_swapper_chk.sv
module csi_swapper_chk
  import csi_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int FACT_W  = 5,
  parameter int LOC_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] addr_in,
  input logic [FACT_W-1:0] factor,
  input logic              wide_mode,
  input logic              cs_large,
  input logic [ADDR_W-1:0] swp_addr_c,
  input logic              en_c,
  input logic [LOC_W-1:0]  lo_c,
  input logic [LOC_W-1:0]  hi_c,
  input logic [1:0]        nbits_c,
  input logic              out_valid
);
  a_r1_group_size: assert property (@(posedge clk) disable iff (!rst_n)
    en_c |-> ((32'd1 << nbits_c) == 32'(factor)));

  a_r2_bad_factor: assert property (@(posedge clk) disable iff (!rst_n)
    !(factor == FACT_W'(2) || factor == FACT_W'(4) || factor == FACT_W'(8)) |-> !en_c);

  a_r5_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(swp_addr_c) == $countones(addr_in));

  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !en_c |-> (swp_addr_c == addr_in));

  a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (factor == FACT_W'(8) && wide_mode && cs_large) |-> !en_c);

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    en_c |-> ((int'(lo_c) + int'(nbits_c) <= int'(hi_c)) &&
              (int'(hi_c) + int'(nbits_c) <= ADDR_W)));

  a_r10_involution: assert property (@(posedge clk) disable iff (!rst_n)
    en_c |-> (ADDR_W'(swap_bits(MAX_W'(swp_addr_c), int'(lo_c), int'(hi_c),
                                int'(nbits_c))) == addr_in));

  if (REG_OUT) begin : g_vld
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
  end
endmodule

bind csi_swapper csi_swapper_chk #(
  .ADDR_W(ADDR_W), .FACT_W(FACT_W), .LOC_W(LOC_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .addr_in    (addr_in),
  .factor     (factor),
  .wide_mode  (wide_mode),
  .cs_large   (cs_large),
  .swp_addr_c (swp_addr_c),
  .en_c       (en_c),
  .lo_c       (lo_c),
  .hi_c       (hi_c),
  .nbits_c    (nbits_c),
  .out_valid  (out_valid)
);

// File: tb/csi_swapper_bench.sv
`timescale 1ns/1ps
module csi_swapper_bench;
  localparam int ADDR_W = 48;
  localparam int SIZE_W = 64;
  localparam int FACT_W = 5;
  localparam int POS_W  = 7;
  localparam int LOC_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [SIZE_W-1:0] cs_size = '0;
  logic [POS_W-1:0]  last_bank = '0;
  logic [FACT_W-1:0] factor = '0;
  logic              wide_mode = 1'b0;
  logic              cs_large = 1'b0;
  logic              out_valid;
  logic [ADDR_W-1:0] addr_out;
  logic [LOC_W-1:0]  lo_bit, hi_bit;
  logic [FACT_W-1:0] factor_out;
  logic              intlv_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csi_swapper u_csi_swapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr_in(addr_in),
    .cs_size(cs_size), .last_bank(last_bank), .factor(factor),
    .wide_mode(wide_mode), .cs_large(cs_large), .out_valid(out_valid),
    .addr_out(addr_out), .lo_bit(lo_bit), .hi_bit(hi_bit),
    .factor_out(factor_out), .intlv_on(intlv_on)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model, written from the requirements.
  function automatic int ref_hi(input logic [SIZE_W-1:0] s);
    for (int b = SIZE_W - 1; b >= 0; b--) if (s[b]) return b;
    return 0;
  endfunction

  function automatic int ref_n(input int f);
    if (f == 2) return 1;
    if (f == 4) return 2;
    if (f == 8) return 3;
    return 0;
  endfunction

  function automatic bit ref_on(input logic [SIZE_W-1:0] s, input int lb,
                                input int f, input bit w, input bit lg);
    int n, lo, hi;
    n = ref_n(f); lo = lb + 1; hi = ref_hi(s);
    if (n == 0 || s == '0) return 1'b0;
    if (f == 8 && w && lg) return 1'b0;
    if (lo + n > hi || hi + n > ADDR_W) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] ref_addr(input logic [ADDR_W-1:0] a,
      input logic [SIZE_W-1:0] s, input int lb, input int f, input bit w, input bit lg);
    logic [ADDR_W-1:0] r;
    int n, lo, hi;
    r = a;
    if (!ref_on(s, lb, f, w, lg)) return r;
    n = ref_n(f); lo = lb + 1; hi = ref_hi(s);
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= lo && i < lo + n) r[i] = a[hi + i - lo];
      if (i >= hi && i < hi + n) r[i] = a[lo + i - hi];
    end
    return r;
  endfunction

  logic [ADDR_W-1:0] last_out;

  // Drive on a falling edge, sample on the next falling edge (one register).
  task automatic apply(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] s,
                       input int lb, input int f, input bit w, input bit lg,
                       input string tag);
    bit on;
    logic [ADDR_W-1:0] ea;
    @(negedge clk);
    in_valid = 1'b1; addr_in = a; cs_size = s; last_bank = POS_W'(lb);
    factor = FACT_W'(f); wide_mode = w; cs_large = lg;
    @(negedge clk);
    on = ref_on(s, lb, f, w, lg);
    ea = ref_addr(a, s, lb, f, w, lg);
    last_out = addr_out;
    check(addr_out == ea, {tag, " R5/R6 addr"}, 64'(addr_out), 64'(ea));
    check(intlv_on == on, {tag, " R1/R2 on"}, 64'(intlv_on), 64'(on));
    check(factor_out == (on ? FACT_W'(f) : '0), {tag, " R1/R2 factor"},
          64'(factor_out), on ? 64'(f) : 64'd0);
    check(int'(lo_bit) == lb + 1, {tag, " R3 lo_bit"}, 64'(lo_bit), 64'(lb + 1));
    check(int'(hi_bit) == ref_hi(s), {tag, " R4 hi_bit"}, 64'(hi_bit), 64'(ref_hi(s)));
    check(out_valid == 1'b1, {tag, " R9 valid"}, 64'(out_valid), 64'd1);
  endtask

  initial begin
    int fac_set[9] = '{2, 4, 8, 2, 4, 8, 0, 3, 16};
    logic [ADDR_W-1:0] a, orig;
    logic [SIZE_W-1:0] s;
    int lb, f;
    bit w, lg;
    void'($urandom(32'd20240611));

    // R9: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
    check(addr_out == '0, "R9 reset addr", 64'(addr_out), 64'd0);
    check(intlv_on == 1'b0 && factor_out == '0, "R9 reset flags",
          64'({intlv_on, factor_out}), 64'd0);
    rst_n = 1'b1;

    // R9: latency of one clock
    @(negedge clk);
    in_valid = 1'b1; addr_in = 48'h1234; cs_size = 64'd1 << 25; last_bank = 7'd12;
    factor = 5'd2;
    #1 check(out_valid == 1'b0, "R9 not yet valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    check(out_valid == 1'b1, "R9 valid after one clock", 64'(out_valid), 64'd1);

    // R1, R5: 32 MB chip-select, bank top bit 12, low group at 13, high at 25
    apply(48'd1 << 13, 64'd1 << 25, 12, 2, 1'b0, 1'b0, "2way");
    check(addr_out == (48'd1 << 25), "R5 bit13 to bit25", 64'(addr_out), 64'd1 << 25);
    apply((48'd1 << 13) | (48'd1 << 26), 64'd1 << 25, 12, 4, 1'b0, 1'b0, "4way");
    check(addr_out == ((48'd1 << 25) | (48'd1 << 14)), "R5 4way pair",
          64'(addr_out), (64'd1 << 25) | (64'd1 << 14));
    apply(48'd1 << 15, 64'd1 << 25, 12, 8, 1'b0, 1'b0, "8way");
    check(addr_out == (48'd1 << 27), "R5 bit15 to bit27", 64'(addr_out), 64'd1 << 27);

    // R2: illegal factors
    apply(48'hABCD_1234_5678, 64'd1 << 25, 12, 3, 1'b0, 1'b0, "R2 f3");
    apply(48'hABCD_1234_5678, 64'd1 << 25, 12, 0, 1'b0, 1'b0, "R2 f0");
    apply(48'hABCD_1234_5678, 64'd1 << 25, 12, 16, 1'b0, 1'b0, "R2 f16");

    // R7: 8-way refusal only for wide bus with largest modes
    apply(48'hFFFF_0000_A000, 64'd1 << 30, 14, 8, 1'b1, 1'b1, "R7 refused");
    check(addr_out == 48'hFFFF_0000_A000, "R7 pass-through", 64'(addr_out),
          64'h0000_FFFF_0000_A000);
    apply(48'hFFFF_0000_A000, 64'd1 << 30, 14, 8, 1'b0, 1'b1, "R7 narrow ok");
    apply(48'hFFFF_0000_A000, 64'd1 << 30, 14, 4, 1'b1, 1'b1, "R7 4way ok");

    // R8: geometry edges
    apply(48'hFFFF, 64'd1 << 15, 12, 4, 1'b0, 1'b0, "R8 touching ok");
    apply(48'hFFFF, 64'd1 << 14, 12, 4, 1'b0, 1'b0, "R8 overlap off");
    apply(48'h8000_0000_0001, 64'd1 << 47, 12, 2, 1'b0, 1'b0, "R8 top ok");
    apply(48'h8000_0000_0001, 64'd1 << 47, 12, 4, 1'b0, 1'b0, "R8 past top off");
    // R4: zero size disables; non-power-of-two uses the leading one
    apply(48'h5555_5555_5555, 64'd0, 12, 2, 1'b0, 1'b0, "R4 zero size");
    apply(48'h5555_5555_5555, 64'h0000_0000_0BAD_F00D, 9, 8, 1'b0, 1'b0, "R4 odd size");

    // Random mix, each active result fed back in (R10)
    for (int it = 0; it < 400; it++) begin
      a  = {$urandom, $urandom} & {ADDR_W{1'b1}};
      case ($urandom % 4)
        0: s = 64'd1 << ($urandom % 44 + 8);
        1: s = {$urandom, $urandom};
        2: s = 64'd1 << ($urandom % 24 + 20);
        default: s = 64'd1 << ($urandom % 16 + 24);
      endcase
      if ($urandom % 40 == 0) s = '0;
      lb = int'($urandom % 20) + 8;
      f  = fac_set[$urandom % 9];
      w  = 1'($urandom);
      lg = 1'($urandom);
      apply(a, s, lb, f, w, lg, "rnd");
      if (intlv_on) begin
        orig = a;
        apply(last_out, s, lb, f, w, lg, "rnd back");
        check(addr_out == orig, "R10 double swap", 64'(addr_out), 64'(orig));
      end
    end

    // R9: out_valid drops one clock after in_valid
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 valid drop", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule